// File: doc/BRIEF.md
# Asynchronous Register-Bus Slave

This block is the processor-side register port of a peripheral attached to a non-multiplexed 8-bit bus. The processor drives an active-low chip select, a read/write line, an address and write data. The block answers every access with one active-low transfer acknowledge. The strobes come from outside the memory clock domain, so they pass through a two-flop synchroniser before any decode. After that, a small state machine serves reads and writes to a register file.

The acknowledge delay depends on the access. Three addresses form a fast class and always answer after a short, fixed number of memory clocks. Reads of any other address take a longer path. That path is longer again when a write ended only a few clocks earlier. A write that closely follows another write is held back until a settling window after the earlier write has elapsed. Write data is committed when the end of the access is seen. Read data is presented, with its output enable, only while the acknowledge is low. One register holds a divisor that sets the period of a divided clock output.

Top module: `regbus_slave`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `ack_n` is high and `data_oe` is low. Every register, the divisor included, resets to 0.
- R2: A read (`rw` = 1) of address 2, 4 or 5 acknowledges after FAST_LAT clocks. Counting the first rising edge that samples `cs_n` low as edge 1, `ack_n` is low after edge FAST_LAT+3.
- R3: A read of any other address acknowledges after edge SLOW_LAT+3 when no write ended recently. A write is recent when the gap g is at most WINDOW, where g is the number of rising edges that sample `cs_n` high between that write and this access.
- R4: A read of a non-fast address whose gap g after the last write is at most WINDOW acknowledges after edge SLOW_WR_LAT+3.
- R5: A write (`rw` = 0) acknowledges after edge K+3, where K = max(FAST_LAT, WINDOW-g+1) and g is the gap since the previous write ended. With no write, or a long gap, K = FAST_LAT.
- R6: A write stores `data_i` into the addressed register. A later read returns that value on `data_o`, and `data_oe` is high only while a read is acknowledged.
- R7: Counting the first rising edge that samples `cs_n` high as edge 1, `ack_n` is high and `data_oe` is low after edge 3.
- R8: Each access gets exactly one acknowledge. `ack_n` falls only at the end of a wait period and stays low for as long as `cs_n` is held low.
- R9: The divisor register sits at address 31. With divisor D ≥ 1, `div_clk` has a period of D+1 memory clocks. With D = 0, `div_clk` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Asynchronous active-low chip select |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | ADDR_W | Register address |
| data_i | input | DATA_W | Write data from the processor |
| data_o | output | DATA_W | Read data to the processor |
| data_oe | output | 1 | Read data drive enable (low = bus released) |
| ack_n | output | 1 | Active-low transfer acknowledge |
| div_clk | output | 1 | Divided clock output |

## Verification
The assertions take for granted that the processor keeps chip select low until it sees the acknowledge. They also assume that address, direction and write data are stable from the fall of chip select until the third clock edge after it rises, and that chip select then stays high for at least three edges. Under those assumptions a single wait period precedes each acknowledge, and its length is bounded by the longest latency class. The stimulus drives every input at the falling clock edge. It only raises chip select after the acknowledge is observed, and it sweeps inter-access gaps from 3 to 9 edges, so both sides of the recent-write window are covered without breaking the hold rule.

// File: rtl/regbus_pkg.sv
// Shared types and helpers for the register-bus slave.
// Assumes: nothing beyond IEEE 1800-2017 semantics.
package regbus_pkg;

    // Access sequencer states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_ACK  = 2'd2
    } bus_state_e;

    // Largest of three latency values
    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/regbus_sync.sv
// Two-flop synchroniser for a bundle of asynchronous level inputs.
// Assumes: each bit is independently meaningful or held stable long enough
// that skew between bits across the two stages does not matter.
module regbus_sync #(
    parameter int             W       = 2,
    parameter logic [W-1:0]   RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    // Two register stages toward the memory clock domain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/regbus_ctrl.sv
// Access sequencer: latches the address and direction on the synchronised
// chip-select fall, selects a wait length by register class and write
// recency, holds writes off inside the settling window, and raises the
// acknowledge until chip select is seen high again.
// Assumes: cs_s/rw_s are already synchronised; addr is stable before cs_s falls.
module regbus_ctrl
    import regbus_pkg::*;
#(
    parameter int ADDR_W      = 5,
    parameter int FAST_LAT    = 2,
    parameter int SLOW_LAT    = 15,
    parameter int SLOW_WR_LAT = 35,
    parameter int WINDOW      = 2,
    parameter int FAST_A0     = 2,
    parameter int FAST_A1     = 4,
    parameter int FAST_A2     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              rw_s,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] addr_q,
    output logic              rw_q,
    output logic              load_rd,
    output logic              wr_en,
    output logic              ack_n,
    output logic              data_oe,
    output logic              in_wait
);
    localparam int MAX_LAT = max3(FAST_LAT, SLOW_LAT, SLOW_WR_LAT);
    localparam int CNT_W   = $clog2(MAX_LAT + 1);
    localparam int SW      = $clog2(WINDOW + 1);

    bus_state_e        state;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  lat_sel;
    logic [SW-1:0]     since_q;
    logic              is_fast;
    logic              recent;
    logic              hold_ok;

    // Register-class and recency decode for the incoming access
    always_comb begin
        is_fast = (int'(addr) == FAST_A0) || (int'(addr) == FAST_A1) ||
                  (int'(addr) == FAST_A2);
        recent  = (since_q < SW'(WINDOW));
        hold_ok = (since_q >= SW'(WINDOW));
        if (!rw_s || is_fast)
            lat_sel = CNT_W'(FAST_LAT);
        else if (recent)
            lat_sel = CNT_W'(SLOW_WR_LAT);
        else
            lat_sel = CNT_W'(SLOW_LAT);
    end

    // Strobes derived from the sequencer state
    always_comb begin
        load_rd = (state == ST_WAIT) && !cs_s && (cnt_q <= CNT_W'(1)) &&
                  (rw_q || hold_ok);
        wr_en   = (state == ST_ACK) && cs_s && !rw_q;
        ack_n   = (state != ST_ACK);
        data_oe = (state == ST_ACK) && rw_q;
        in_wait = (state == ST_WAIT);
    end

    // Sequencer: idle, counted wait, acknowledge until release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt_q  <= '0;
            addr_q <= '0;
            rw_q   <= 1'b1;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (!cs_s) begin
                        addr_q <= addr;
                        rw_q   <= rw_s;
                        cnt_q  <= lat_sel;
                        state  <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (cs_s)
                        state <= ST_IDLE;
                    else if (load_rd)
                        state <= ST_ACK;
                    else if (cnt_q > CNT_W'(1))
                        cnt_q <= cnt_q - CNT_W'(1);
                end
                ST_ACK: begin
                    if (cs_s)
                        state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Clocks elapsed since the last write was released, saturating at WINDOW
    always_ff @(posedge clk) begin
        if (!rst_n)
            since_q <= SW'(WINDOW);
        else if (wr_en)
            since_q <= '0;
        else if (since_q < SW'(WINDOW))
            since_q <= since_q + SW'(1);
    end
endmodule

// File: rtl/regbus_regfile.sv
// Register storage with a combinational read port and one write port; also
// exposes the divisor register to the clock divider.
// Assumes: at most one write per clock.
module regbus_regfile #(
    parameter int ADDR_W    = 5,
    parameter int DATA_W    = 8,
    parameter int CDIV_ADDR = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] divisor
);
    localparam int NREG = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        // One storage word, loaded when its address is written
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[i] <= '0;
            else if (we && (waddr == ADDR_W'(i)))
                mem[i] <= wdata;
        end
    end

    // Read mux and divisor tap
    always_comb begin
        rdata   = mem[raddr];
        divisor = mem[CDIV_ADDR];
    end
endmodule

// File: rtl/regbus_clkdiv.sv
// Programmable divider: period of D+1 input clocks for D >= 1, high for
// the first half (rounded up); D = 0 holds the output high.
// Assumes: divisor may change at any time; the counter wraps safely.
module regbus_clkdiv #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] divisor,
    output logic              div_clk
);
    logic [DATA_W-1:0] cnt_q;
    logic [DATA_W-1:0] cnt_nxt;

    // Next phase count, wrapping after the divisor value
    always_comb begin
        cnt_nxt = (cnt_q >= divisor) ? '0 : cnt_q + DATA_W'(1);
    end

    // Phase counter and registered output level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            div_clk <= 1'b1;
        end else begin
            cnt_q   <= cnt_nxt;
            div_clk <= (cnt_nxt <= (divisor >> 1));
        end
    end
endmodule

// File: rtl/regbus_slave.sv
// Top of the register-bus slave: synchroniser, access sequencer, register
// file, read-data holding register and divided clock output.
// Assumes: address, direction and write data stay stable from chip-select
// fall until three clocks after chip-select rise; chip select stays low
// until the acknowledge is seen.
module regbus_slave
    import regbus_pkg::*;
#(
    parameter int ADDR_W      = 5,
    parameter int DATA_W      = 8,
    parameter int FAST_LAT    = 2,
    parameter int SLOW_LAT    = 15,
    parameter int SLOW_WR_LAT = 35,
    parameter int WINDOW      = 2,
    parameter int FAST_A0     = 2,
    parameter int FAST_A1     = 4,
    parameter int FAST_A2     = 5,
    parameter int CDIV_ADDR   = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rw,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] data_o,
    output logic              data_oe,
    output logic              ack_n,
    output logic              div_clk
);
    localparam int MAX_WAIT = max3(SLOW_WR_LAT, WINDOW + 1, max3(FAST_LAT, SLOW_LAT, 1));

    logic [1:0]        sync_q;
    logic              cs_s;
    logic              rw_s;
    logic [ADDR_W-1:0] addr_q;
    logic              rw_q;
    logic              load_rd;
    logic              wr_en;
    logic              in_wait;
    logic [DATA_W-1:0] rdata;
    logic [DATA_W-1:0] div_val;

    regbus_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, rw}),
        .q     (sync_q)
    );

    // Split the synchronised strobes
    always_comb begin
        cs_s = sync_q[1];
        rw_s = sync_q[0];
    end

    regbus_ctrl #(
        .ADDR_W(ADDR_W), .FAST_LAT(FAST_LAT), .SLOW_LAT(SLOW_LAT),
        .SLOW_WR_LAT(SLOW_WR_LAT), .WINDOW(WINDOW),
        .FAST_A0(FAST_A0), .FAST_A1(FAST_A1), .FAST_A2(FAST_A2)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_s    (cs_s),
        .rw_s    (rw_s),
        .addr    (addr),
        .addr_q  (addr_q),
        .rw_q    (rw_q),
        .load_rd (load_rd),
        .wr_en   (wr_en),
        .ack_n   (ack_n),
        .data_oe (data_oe),
        .in_wait (in_wait)
    );

    regbus_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CDIV_ADDR(CDIV_ADDR)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wr_en),
        .waddr   (addr_q),
        .wdata   (data_i),
        .raddr   (addr_q),
        .rdata   (rdata),
        .divisor (div_val)
    );

    // Hold read data steady for the whole acknowledge phase
    always_ff @(posedge clk) begin
        if (!rst_n)
            data_o <= '0;
        else if (load_rd)
            data_o <= rdata;
    end

    regbus_clkdiv #(.DATA_W(DATA_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .divisor (div_val),
        .div_clk (div_clk)
    );
endmodule

// File: rtl/regbus_slave_chk.sv
// Checker for the register-bus slave, attached by bind.
// Assumes: the processor keeps cs_n low until the acknowledge arrives.
module regbus_slave_chk #(
    parameter int DATA_W   = 8,
    parameter int MAX_WAIT = 35
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_s,
    input logic              ack_n,
    input logic              data_oe,
    input logic              div_clk,
    input logic [DATA_W-1:0] div_val,
    input logic              in_wait
);
    logic [15:0] wcnt;

    // Length of the current wait period
    always_ff @(posedge clk) begin
        if (!rst_n)
            wcnt <= '0;
        else if (in_wait)
            wcnt <= wcnt + 16'd1;
        else
            wcnt <= '0;
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (ack_n && !data_oe)); // R1

    AST_OE_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> !ack_n); // R6

    AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_n && !cs_s) |=> !ack_n); // R8

    AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_n && cs_s) |=> (ack_n && !data_oe)); // R7

    AST_ACK_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_n) |-> $past(in_wait)); // R8

    AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        in_wait |-> (int'(wcnt) < MAX_WAIT)); // R4

    AST_DIV_ZERO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ((div_val == '0) && ($past(div_val) == '0)) |-> div_clk); // R9
endmodule

bind regbus_slave regbus_slave_chk #(.DATA_W(DATA_W), .MAX_WAIT(MAX_WAIT)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_s    (cs_s),
    .ack_n   (ack_n),
    .data_oe (data_oe),
    .div_clk (div_clk),
    .div_val (div_val),
    .in_wait (in_wait)
);

// File: tb/tb_regbus_slave.sv
`timescale 1ns/1ps
module tb_regbus_slave;
    localparam int AW    = 5;
    localparam int DW    = 8;
    localparam int FAST  = 2;
    localparam int SLOW  = 5;
    localparam int SLOWW = 9;
    localparam int WIN   = 6;
    localparam int LONG  = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cs_n;
    logic          rw;
    logic [AW-1:0] addr;
    logic [DW-1:0] data_i;
    logic [DW-1:0] data_o;
    logic          data_oe;
    logic          ack_n;
    logic          div_clk;

    int errs   = 0;
    int checks = 0;

    regbus_slave #(
        .ADDR_W(AW), .DATA_W(DW), .FAST_LAT(FAST), .SLOW_LAT(SLOW),
        .SLOW_WR_LAT(SLOWW), .WINDOW(WIN)
    ) dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rw(rw), .addr(addr),
        .data_i(data_i), .data_o(data_o), .data_oe(data_oe),
        .ack_n(ack_n), .div_clk(div_clk)
    );

    always #4 clk = ~clk;

    function automatic int pat(input int a);
        return (a * 13 + 5) & 8'hFF;
    endfunction

    function automatic bit fast_addr(input int a);
        return (a == 2) || (a == 4) || (a == 5);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One access: wait gap edges with cs_n high, assert cs_n, measure the
    // acknowledge edge, check data, optionally hold, then release.
    task automatic access(input bit rd, input int a, input int wd, input int gap,
                          input int exp_k, input int exp_rd, input string req,
                          input int hold);
        int n;
        repeat (gap) @(negedge clk);
        rw = rd; addr = AW'(a); data_i = DW'(wd); cs_n = 1'b0;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (ack_n && n < 100);
        chk(n == exp_k + 3, req, n, exp_k + 3);
        if (rd) begin
            chk(data_oe == 1'b1, "R6 oe on read", int'(data_oe), 1);
            chk(int'(data_o) == exp_rd, req, int'(data_o), exp_rd);
        end else begin
            chk(data_oe == 1'b0, "R6 oe off on write", int'(data_oe), 0);
        end
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk(ack_n == 1'b0, "R8 ack held", int'(ack_n), 0);
        end
        cs_n = 1'b1;
    endtask

    // Watchdog: an expired run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errs++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        int k;
        int prev;
        int cnt;
        rst_n = 1'b0; cs_n = 1'b1; rw = 1'b1; addr = '0; data_i = '0;
        repeat (4) @(negedge clk);
        chk(ack_n == 1'b1, "R1 ack idle", int'(ack_n), 1);
        chk(data_oe == 1'b0, "R1 oe idle", int'(data_oe), 0);
        chk(div_clk == 1'b1, "R1 div_clk reset", int'(div_clk), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ack_n == 1'b1, "R1 ack after reset", int'(ack_n), 1);

        // R9: divisor resets to 0, so the divided clock stays high
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(div_clk == 1'b1, "R9 div zero high", int'(div_clk), 1);
        end

        // R5/R6: preload with long gaps, write latency is FAST_LAT
        for (int a = 0; a < 31; a++)
            access(1'b0, a, pat(a), LONG, FAST, 0, "R5 write latency", 0);

        // R2/R3/R6: read back every register, no recent write
        for (int a = 0; a < 31; a++)
            access(1'b1, a, 0, LONG, fast_addr(a) ? FAST : SLOW, pat(a),
                   fast_addr(a) ? "R2 fast read" : "R3 slow read", 0);

        // Sweep of the gap after a write across the recency window
        for (int g = 3; g <= 9; g++) begin
            access(1'b0, 10, pat(10), LONG, FAST, 0, "R5 write latency", 0);
            access(1'b1, 4, 0, g, FAST, pat(4), "R2 fast read after write", 0);
            access(1'b0, 10, pat(10), LONG, FAST, 0, "R5 write latency", 0);
            k = (g <= WIN) ? SLOWW : SLOW;
            access(1'b1, 7, 0, g, k, pat(7),
                   (g <= WIN) ? "R4 slow read recent" : "R3 slow read not recent", 0);
            access(1'b0, 10, pat(10), LONG, FAST, 0, "R5 write latency", 0);
            k = (WIN - g + 1 > FAST) ? WIN - g + 1 : FAST;
            access(1'b0, 9, pat(9), g, k, 0, "R5 write holdoff", 0);
        end
        access(1'b1, 9, 0, LONG, SLOW, pat(9), "R6 readback", 0);

        // R7/R8: hold cs low, then check release timing
        for (int r = 0; r < 2; r++) begin
            if (r == 0)
                access(1'b1, 5, 0, LONG, FAST, pat(5), "R2 fast read", 4);
            else
                access(1'b0, 12, pat(12), LONG, FAST, 0, "R5 write latency", 4);
            @(negedge clk);
            chk(ack_n == 1'b0, "R7 ack before release", int'(ack_n), 0);
            @(negedge clk);
            chk(ack_n == 1'b0, "R7 ack before release", int'(ack_n), 0);
            @(negedge clk);
            chk(ack_n == 1'b1, "R7 ack released", int'(ack_n), 1);
            chk(data_oe == 1'b0, "R7 bus released", int'(data_oe), 0);
        end

        // R9: divided clock period for divisor values 1..6
        for (int d = 1; d <= 6; d++) begin
            access(1'b0, 31, d, LONG, FAST, 0, "R5 write latency", 0);
            repeat (24) @(negedge clk);
            prev = int'(div_clk);
            cnt = 0;
            do begin
                @(negedge clk);
                cnt++;
                k = prev;
                prev = int'(div_clk);
            end while (!(k == 0 && prev == 1) && cnt < 50);
            cnt = 0;
            do begin
                @(negedge clk);
                cnt++;
                k = prev;
                prev = int'(div_clk);
            end while (!(k == 0 && prev == 1) && cnt < 50);
            chk(cnt == d + 1, "R9 div period", cnt, d + 1);
        end
        access(1'b1, 31, 0, LONG, SLOW, 6, "R6 divisor readback", 0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule